// File: doc/BRIEF.md
# Paced Packet Transmitter

This block sends words held in an on-chip payload store as a stream of fixed-length packets. Each 64-bit word is made from two 32-bit banks that share one address. The upper bank supplies bits 63:32 and the lower bank supplies bits 31:0. A write port loads either bank one half-word at a time. Three configuration inputs control the stream: a packet length in words, a 7-bit pacing value and a transmit enable.

The output is a valid/ready word stream, and a last flag marks the final word of each packet. A 7-bit phase accumulator throttles the rate at which words are issued. Every cycle it adds (pace+1), and each carry out of bit 6 grants one issue opportunity. A pace setting p therefore allows p+1 words in every 128 cycles. Opportunities that arrive while the consumer stalls are held in a small credit bank and are used once the stall ends.

Top module: `paced_pkt_tx`

## Requirements
- R1: The word at address a is {upper[a], lower[a]}, with the upper bank in bits 63:32. A write with `mem_wr_hi`=1 changes only the upper bank and a write with `mem_wr_hi`=0 changes only the lower bank. Each bank holds 2^ADDR_W entries.
- R2: A packet carries addresses 0 to L-1 in ascending order. `tx_last` is high with the word at address L-1 and low with every other word.
- R3: A length of 0 sends nothing. A length greater than 2^ADDR_W is clamped to 2^ADDR_W. The length is captured when a packet starts.
- R4: With a steady pace p, exactly p+1 issue opportunities arise in every 128 cycles. Each opportunity is used or banked. A word is never issued without one. At p=127, a packet of L words with ready held high occupies L consecutive cycles.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` stay unchanged on the next cycle.
- R6: Opportunities that arrive during a stall are banked, up to CREDIT_MAX of them. When ready returns, the banked words follow the held word on back-to-back cycles.
- R7: No packet starts while `cfg_enable` is low. If enable is cleared in the middle of a packet, that packet still completes and then the stream goes idle.
- R8: During and right after reset, `tx_valid` is low, and the pacing phase and the credit bank are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_wr_en | input | 1 | Payload store write strobe |
| mem_wr_hi | input | 1 | 1 selects the upper bank, 0 selects the lower bank |
| mem_wr_addr | input | ADDR_W | Write address |
| mem_wr_data | input | 32 | Write data |
| cfg_len | input | LEN_W | Packet length in words |
| cfg_pace | input | 7 | Pacing value p (p+1 words per 128 cycles) |
| cfg_enable | input | 1 | Transmit enable |
| tx_ready | input | 1 | Consumer ready |
| tx_valid | output | 1 | Output word valid |
| tx_data | output | 64 | Output word |
| tx_last | output | 1 | Last word of the packet |

## Verification
A pacing carry can land in the same cycle as a consumer stall. The block must then bank the carry rather than drop it. The bench provokes this with the slowest pace and a short packet. It holds ready low for several hundred cycles, so many carries arrive while a word waits. When ready returns, the bench expects the held word plus exactly CREDIT_MAX banked words on consecutive cycles; one further word is tolerated if a new carry lands inside the window. After that, it expects no more than one word in the next 60 cycles. A handshake that coincides with a new issue is judged by the stall-stability check and by the per-word data comparison.

// File: rtl/tx_pkg.sv
`timescale 1ns/100ps
package tx_pkg;
    localparam int PACE_W = 7;
    localparam int HALF_W = 32;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic valid;
        logic last;
    } out_flags_t;
endpackage

// File: rtl/tx_pace_credit.sv
`timescale 1ns/100ps
module tx_pace_credit
    import tx_pkg::*;
#(
    parameter int CREDIT_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PACE_W-1:0] pace,
    input  logic              take,
    output logic              avail
);
    localparam int CW = $clog2(CREDIT_MAX + 1);

    logic [PACE_W-1:0] phase;
    logic [PACE_W:0]   sum;
    logic              carry;
    logic [CW-1:0]     bank;

    assign sum   = {1'b0, phase} + {1'b0, pace} + {{PACE_W{1'b0}}, 1'b1};
    assign carry = sum[PACE_W];
    assign avail = carry || (bank != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            bank  <= '0;
        end else begin
            phase <= sum[PACE_W-1:0];
            if (carry && !take) begin
                if (bank < CW'(CREDIT_MAX)) bank <= bank + 1'b1;
            end else if (!carry && take) begin
                bank <= bank - 1'b1;
            end
        end
    end

    // R6: the credit bank never passes its cap
    assert_bank_cap_R6: assert property (@(posedge clk) disable iff (rst)
        bank <= CW'(CREDIT_MAX));
    // R4: an issue without a fresh carry must be backed by a banked credit
    assert_take_backed_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !carry) |-> (bank != '0));
endmodule

// File: rtl/tx_seq.sv
`timescale 1ns/100ps
module tx_seq
    import tx_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              issue,
    output logic              active,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int LW    = ADDR_W + 1;

    seq_state_e        state;
    logic [LW-1:0]     len_q;
    logic [LW-1:0]     eff_len;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        if (len_in > LEN_W'(DEPTH)) eff_len = LW'(DEPTH);
        else                        eff_len = len_in[LW-1:0];
    end

    assign active = (state == SEQ_RUN);
    assign addr   = addr_q;
    assign last   = ({1'b0, addr_q} == len_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            len_q  <= '0;
            addr_q <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (enable && eff_len != '0) begin
                        state  <= SEQ_RUN;
                        len_q  <= eff_len;
                        addr_q <= '0;
                    end
                end
                SEQ_RUN: begin
                    if (issue) begin
                        if (last) state  <= SEQ_IDLE;
                        else      addr_q <= addr_q + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R3: while a packet runs, the address stays below the captured length
    assert_addr_in_len_R3: assert property (@(posedge clk) disable iff (rst)
        active |-> ({1'b0, addr_q} < len_q));
endmodule

// File: rtl/tx_payload_mem.sv
`timescale 1ns/100ps
module tx_payload_mem
    import tx_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF_W-1:0] store [DEPTH];
        logic [HALF_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_hi == 1'(h))) store[wr_addr] <= wr_data;
            if (rd_en) q <= store[rd_addr];
        end

        assign rd_word[HALF_W*h +: HALF_W] = q;
    end
endmodule

// File: rtl/paced_pkt_tx.sv
`timescale 1ns/100ps
module paced_pkt_tx
    import tx_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int LEN_W      = 16,
    parameter int CREDIT_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mem_wr_en,
    input  logic              mem_wr_hi,
    input  logic [ADDR_W-1:0] mem_wr_addr,
    input  logic [31:0]       mem_wr_data,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [6:0]        cfg_pace,
    input  logic              cfg_enable,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [63:0]       tx_data,
    output logic              tx_last
);
    logic              avail;
    logic              active;
    logic              seq_last;
    logic [ADDR_W-1:0] seq_addr;
    logic              issue;
    out_flags_t        flags;

    assign issue = active && avail && (!flags.valid || tx_ready);

    tx_pace_credit #(.CREDIT_MAX(CREDIT_MAX)) u_pace (
        .clk   (clk),
        .rst   (rst),
        .pace  (cfg_pace),
        .take  (issue),
        .avail (avail)
    );

    tx_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg_enable),
        .len_in (cfg_len),
        .issue  (issue),
        .active (active),
        .addr   (seq_addr),
        .last   (seq_last)
    );

    tx_payload_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_en   (mem_wr_en),
        .wr_hi   (mem_wr_hi),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .rd_en   (issue),
        .rd_addr (seq_addr),
        .rd_word (tx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (issue) begin
            flags.valid <= 1'b1;
            flags.last  <= seq_last;
        end else if (tx_ready) begin
            flags.valid <= 1'b0;
        end
    end

    assign tx_valid = flags.valid;
    assign tx_last  = flags.last;

    // R5: a stalled word holds its data and flags
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
    // R7: with enable low and no packet running, the accepted word is the final one
    assert_idle_drain_R7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_enable && !active && tx_valid && tx_ready) |=> !tx_valid);
endmodule

// File: tb/test_paced_pkt_tx.sv
`timescale 1ns/100ps
module test_paced_pkt_tx;
    localparam int ADDR_W = 10;
    localparam int LEN_W  = 16;
    localparam int CMAX   = 4;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              mem_wr_en;
    logic              mem_wr_hi;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [31:0]       mem_wr_data;
    logic [LEN_W-1:0]  cfg_len;
    logic [6:0]        cfg_pace;
    logic              cfg_enable;
    logic              tx_ready;
    logic              tx_valid;
    logic [63:0]       tx_data;
    logic              tx_last;

    paced_pkt_tx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CREDIT_MAX(CMAX)) i_paced_pkt_tx (
        .clk(clk), .rst(rst), .mem_wr_en(mem_wr_en), .mem_wr_hi(mem_wr_hi),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .cfg_len(cfg_len),
        .cfg_pace(cfg_pace), .cfg_enable(cfg_enable), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [31:0] up_m [DEPTH];
    logic [31:0] lo_m [DEPTH];
    int exp_len = 1;
    int exp_idx = 0;
    int pkts = 0;
    int acc_cnt = 0;
    int valid_cnt = 0;
    int first_cyc = 0;
    int last_cyc = 0;
    int last_pkt_words = 0;
    int rdy_mode = 0;
    bit mon_en = 0;
    bit done = 0;
    logic [63:0] word_idx2;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] up_pat(input int a);
        return a * 32'h9E3779B1 + 32'h0000_1234;
    endfunction
    function automatic logic [31:0] lo_pat(input int a);
        return ~(a * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction
    function automatic int clamp(input int l);
        return (l > DEPTH) ? DEPTH : l;
    endfunction

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    initial forever begin
        @(posedge clk);
        #2;
        case (rdy_mode)
            0: tx_ready = 1'b0;
            1: tx_ready = 1'b1;
            default: tx_ready = ($urandom % 4) != 0;
        endcase
    end

    // monitor: sampled at the falling edge, away from the active edge
    initial begin
        bit          prev_stall;
        logic [63:0] prev_data;
        logic        prev_last;
        prev_stall = 0;
        prev_data  = '0;
        prev_last  = 0;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                if (prev_stall) begin
                    chk(tx_valid == 1'b1, "R5", "valid held", 64'(tx_valid), 64'd1);
                    chk(tx_data == prev_data, "R5", "data held", tx_data, prev_data);
                    chk(tx_last == prev_last, "R5", "last held", 64'(tx_last), 64'(prev_last));
                end
                if (tx_valid) valid_cnt++;
                if (tx_valid && tx_ready) begin
                    chk(tx_data == {up_m[exp_idx], lo_m[exp_idx]}, "R1", "word",
                        tx_data, {up_m[exp_idx], lo_m[exp_idx]});
                    chk(tx_last == (exp_idx == exp_len - 1), "R2", "last flag",
                        64'(tx_last), 64'(exp_idx == exp_len - 1));
                    if (exp_idx == 2) word_idx2 = tx_data;
                    if (exp_idx == 0) first_cyc = cyc;
                    acc_cnt++;
                    if (tx_last) begin
                        last_cyc = cyc;
                        last_pkt_words = exp_idx + 1;
                        pkts++;
                        exp_idx = 0;
                    end else begin
                        exp_idx++;
                    end
                end
                prev_stall = tx_valid && !tx_ready;
                prev_data  = tx_data;
                prev_last  = tx_last;
            end
        end
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input int len, input int pace);
        cfg_len  = LEN_W'(len);
        cfg_pace = 7'(pace);
        exp_len  = clamp(len);
    endtask

    task automatic pulse_enable();
        cfg_enable = 1'b1;
        step(1);
        cfg_enable = 1'b0;
    endtask

    task automatic wait_pkts(input int target, input int limit, input string req);
        int n = 0;
        while (pkts < target && n < limit) begin
            step(1);
            n++;
        end
        chk(pkts >= target, req, "packet completion", 64'(pkts), 64'(target));
    endtask

    task automatic wr(input bit hi, input int a, input logic [31:0] d);
        mem_wr_en   = 1'b1;
        mem_wr_hi   = hi;
        mem_wr_addr = ADDR_W'(a);
        mem_wr_data = d;
        step(1);
        mem_wr_en   = 1'b0;
        if (hi) up_m[a] = d;
        else    lo_m[a] = d;
    endtask

    initial begin
        int a0, p0;
        void'($urandom(32'd20240607));
        word_idx2 = '0;
        rst = 1'b1; mem_wr_en = 1'b0; mem_wr_hi = 1'b0; mem_wr_addr = '0; mem_wr_data = '0;
        cfg_len = '0; cfg_pace = '0; cfg_enable = 1'b0; tx_ready = 1'b0;
        step(3);
        chk(tx_valid == 1'b0, "R8", "valid in reset", 64'(tx_valid), 64'd0);
        rst = 1'b0;
        step(1);
        chk(tx_valid == 1'b0, "R8", "valid after reset", 64'(tx_valid), 64'd0);

        for (int a = 0; a < DEPTH; a++) begin
            wr(1'b1, a, up_pat(a));
            wr(1'b0, a, lo_pat(a));
        end
        step(2);
        chk(tx_valid == 1'b0, "R7", "no start with enable low", 64'(tx_valid), 64'd0);
        mon_en = 1;

        // R4 full rate, R2 ordering
        rdy_mode = 1;
        set_cfg(16, 127);
        p0 = pkts;
        pulse_enable();
        wait_pkts(p0 + 1, 200, "R2");
        chk(last_cyc - first_cyc == 15, "R4", "full-rate span", 64'(last_cyc - first_cyc), 64'd15);
        chk(last_pkt_words == 16, "R2", "packet size", 64'(last_pkt_words), 64'd16);
        step(20);
        chk(pkts == p0 + 1, "R7", "single packet after pulse", 64'(pkts), 64'(p0 + 1));

        // R3 clamp
        set_cfg(DEPTH + 5, 127);
        p0 = pkts;
        pulse_enable();
        wait_pkts(p0 + 1, DEPTH + 200, "R3");
        chk(last_pkt_words == DEPTH, "R3", "clamped length", 64'(last_pkt_words), 64'(DEPTH));

        // R3 zero length
        set_cfg(0, 127);
        a0 = valid_cnt;
        cfg_enable = 1'b1;
        step(200);
        cfg_enable = 1'b0;
        step(5);
        chk(valid_cnt == a0, "R3", "zero length sends nothing", 64'(valid_cnt), 64'(a0));

        // R7 enable cleared mid-packet
        rdy_mode = 2;
        set_cfg(200, 127);
        p0 = pkts;
        a0 = acc_cnt;
        cfg_enable = 1'b1;
        while (acc_cnt < a0 + 50) step(1);
        cfg_enable = 1'b0;
        step(600);
        chk(pkts == p0 + 1, "R7", "current packet finishes", 64'(pkts), 64'(p0 + 1));
        chk(exp_idx == 0, "R7", "no partial packet", 64'(exp_idx), 64'd0);
        a0 = valid_cnt;
        step(100);
        chk(valid_cnt == a0, "R7", "idle after finish", 64'(valid_cnt), 64'(a0));

        // R4 pacing at 89 -> 90 of 128 cycles
        rdy_mode = 1;
        set_cfg(DEPTH, 89);
        cfg_enable = 1'b1;
        step(300);
        a0 = acc_cnt;
        step(1280);
        chk((acc_cnt - a0 >= 895) && (acc_cnt - a0 <= 905), "R4", "rate at pace 89",
            64'(acc_cnt - a0), 64'd900);
        cfg_enable = 1'b0;
        p0 = pkts;
        wait_pkts(p0 + 1, 2000, "R7");
        step(5);

        // R6 credits banked during a long stall
        rdy_mode = 0;
        set_cfg(8, 0);
        p0 = pkts;
        pulse_enable();
        step(800);
        chk(tx_valid == 1'b1, "R5", "word waiting in stall", 64'(tx_valid), 64'd1);
        a0 = acc_cnt;
        rdy_mode = 1;
        step(8);
        chk((acc_cnt - a0 >= CMAX + 1) && (acc_cnt - a0 <= CMAX + 2), "R6", "burst after stall",
            64'(acc_cnt - a0), 64'(CMAX + 1));
        a0 = acc_cnt;
        step(60);
        chk(acc_cnt - a0 <= 1, "R6", "bank drained", 64'(acc_cnt - a0), 64'd1);
        wait_pkts(p0 + 1, 600, "R6");

        // R1 half-word writes
        wr(1'b1, 2, 32'hCAFE_F00D);
        set_cfg(4, 127);
        p0 = pkts;
        pulse_enable();
        wait_pkts(p0 + 1, 100, "R1");
        chk(word_idx2 == {32'hCAFE_F00D, lo_pat(2)}, "R1", "upper-only write",
            word_idx2, {32'hCAFE_F00D, lo_pat(2)});
        wr(1'b0, 2, 32'h0BAD_BEEF);
        p0 = pkts;
        pulse_enable();
        wait_pkts(p0 + 1, 100, "R1");
        chk(word_idx2 == {32'hCAFE_F00D, 32'h0BAD_BEEF}, "R1", "lower-only write",
            word_idx2, {32'hCAFE_F00D, 32'h0BAD_BEEF});

        // random packets with random ready (R2, R4, R5)
        rdy_mode = 2;
        for (int r = 0; r < 8; r++) begin
            set_cfg(1 + ($urandom % 60), 32 + ($urandom % 96));
            p0 = pkts;
            pulse_enable();
            wait_pkts(p0 + 1, 2000, "R2");
            step(3);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule